// File: doc/BRIEF.md
# Pin-shared SPI master for a multi-mode serial port

This block is the SPI master engine of a serial port whose function is chosen by a 3-bit mode field. Mode values 0 to 3 are the UART variants: 0 is 8-bit, 1 and 2 are 9-bit at a fixed rate, and 3 is 9-bit at a variable rate. Values 5 to 7 are reserved. Value 4 selects the SPI master. The UART logic lives elsewhere, and this block only has to recognise that those values are not SPI. In SPI mode the port's transmit pin carries the serial clock and its receive pin carries MOSI. MISO enters on a separate input. Slave select is not part of the block: software drives it on a general-purpose pin.

Software starts a transfer by writing a byte. The engine then produces exactly eight clock periods and shifts the byte out while it shifts one in. It latches the received byte into a readable buffer and raises a completion flag. One speed bit selects a bit clock of the system clock divided by 4 or by 12. Clock polarity is not a separate setting. The clock pin holds an idle level given by an input, and the transfer toggles the pin starting from that level. The phase input and the data-order input complete the four SPI modes.

Top module: `uart_spi_master`

## Requirements
- R1: While reset is asserted, with mode 4 and idle level 0: busy_o, done_o and wcol_o are 0, rdata_o is 0x00, and txd_o and rxd_o are 0.
- R2: Only mode_i == 4 enables the engine. For any other value, a write starts nothing and sets no flag, and txd_o and rxd_o are held at 1. If mode_i leaves 4 during a transfer, the transfer aborts and done_o stays 0.
- R3: Each half-period of the clock on txd_o lasts 2 system clocks when fast_i=1 and 6 when fast_i=0. The first half-period is measured from the clock edge that accepts the write, and it is full length.
- R4: Outside a transfer, txd_o follows idle_lvl_i. A transfer makes exactly 16 toggles of txd_o, and the last one returns it to the idle level.
- R5: lsb_first_i=0 sends and receives bit 7 first. lsb_first_i=1 sends and receives bit 0 first. The received byte always appears in rdata_o with its natural bit weights.
- R6: With cpha_i=0, the first data bit is on rxd_o before the first clock toggle. MISO is sampled on the odd-numbered (leading) toggles, and rxd_o changes only on the even-numbered (trailing) toggles.
- R7: With cpha_i=1, rxd_o takes each new bit on a leading toggle and MISO is sampled on the trailing toggles.
- R8: done_o rises in the cycle of the 16th toggle, and at that point rdata_o holds the received byte. A 1 on clr_done_i clears done_o. A completing transfer has priority over a clear.
- R9: A write while busy is ignored: the byte in flight is unchanged and wcol_o is set. A 1 on clr_wcol_i clears wcol_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Serial port mode field; 4 selects SPI master |
| fast_i | input | 1 | 1: bit clock = clock/4; 0: clock/12 |
| lsb_first_i | input | 1 | Data order: 1 sends LSB first |
| cpha_i | input | 1 | Clock phase |
| idle_lvl_i | input | 1 | Idle level of the clock pin (sets polarity) |
| wr_i | input | 1 | Write strobe for the transmit byte |
| wdata_i | input | 8 | Byte to send |
| clr_done_i | input | 1 | Clear completion flag when 1 |
| clr_wcol_i | input | 1 | Clear write-collision flag when 1 |
| miso_i | input | 1 | Serial data from the slave |
| txd_o | output | 1 | Transmit pin; serial clock in SPI mode |
| rxd_o | output | 1 | Receive pin; MOSI in SPI mode |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Transfer-complete flag |
| wcol_o | output | 1 | Write-collision flag |
| rdata_o | output | 8 | Last received byte |

## Verification
The transfers cover all four combinations of idle level and phase, each run with both data orders and both speeds. A phase error shows up as a shifted MOSI capture, an order error as a bit-reversed byte, and a divider error as a wrong toggle spacing. The byte pairs include asymmetric patterns, all-zeros against all-ones, and single set bits at either end. These separate a reversal bug from an off-by-one shift, and they separate a dropped last sample from a stale first bit. Further runs cover a mid-transfer write, every non-SPI mode value, and a mode change during a transfer, so the collision, ignore and abort paths are each seen at the pins.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  typedef enum logic [2:0] {
    PM_UART8     = 3'd0,
    PM_UART9_A   = 3'd1,
    PM_UART9_B   = 3'd2,
    PM_UART9_VAR = 3'd3,
    PM_SPI_MST   = 3'd4,
    PM_RSV5      = 3'd5,
    PM_RSV6      = 3'd6,
    PM_RSV7      = 3'd7
  } port_mode_e;

  function automatic logic mode_is_spi(input logic [2:0] m);
    return port_mode_e'(m) == PM_SPI_MST;
  endfunction
endpackage

// File: rtl/spi_bit_timer.sv
module spi_bit_timer #(
  parameter int FAST_DIV = 4,
  parameter int SLOW_DIV = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  input  logic fast_i,
  output logic tick_o
);
  localparam int FAST_HALF = FAST_DIV / 2;
  localparam int SLOW_HALF = SLOW_DIV / 2;
  localparam int MAX_HALF  = (FAST_HALF > SLOW_HALF) ? FAST_HALF : SLOW_HALF;
  localparam int CW        = $clog2(MAX_HALF + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;
  logic          fast_q;

  // speed is latched at start so a mid-byte change cannot stretch a half-period
  assign limit  = fast_q ? CW'(FAST_HALF - 1) : CW'(SLOW_HALF - 1);
  assign tick_o = run_i && (cnt_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      fast_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= '0;
      fast_q <= fast_i;
    end else if (!run_i || tick_o) begin
      cnt_q  <= '0;
    end else begin
      cnt_q  <= cnt_q + CW'(1);
    end
  end

  // R3: a half-period is never shorter than two clocks at the default divisors
  a_r3_no_back_to_back_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && FAST_HALF >= 2 && SLOW_HALF >= 2) |=> !tick_o);
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         abort_i,
  input  logic         tick_i,
  input  logic [W-1:0] data_i,
  input  logic         lsb_i,
  input  logic         cpha_i,
  input  logic         idle_i,
  input  logic         miso_i,
  output logic         busy_o,
  output logic         sclk_o,
  output logic         mosi_o,
  output logic         last_o,
  output logic [W-1:0] rx_o
);
  localparam int EDGES = 2 * W;
  localparam int EW    = $clog2(EDGES);

  logic          busy_q, sclk_q, cpha_q, lsb_q, idle_q;
  logic [W-1:0]  tx_q, rx_q;
  logic [EW-1:0] ecnt_q;
  logic [W-1:0]  data_rev, data_ord, rx_fin, rx_rev;
  logic          leading;

  for (genvar gi = 0; gi < W; gi++) begin : g_rev
    assign data_rev[gi] = data_i[W-1-gi];
    assign rx_rev[gi]   = rx_fin[W-1-gi];
  end

  // shifter always runs MSB-out; LSB-first is handled by reversing at load and unload
  assign data_ord = lsb_i ? data_rev : data_i;
  assign leading  = ~ecnt_q[0];
  assign last_o   = busy_q && tick_i && (ecnt_q == EW'(EDGES - 1));
  // with cpha=1 the final sample lands in the same cycle as completion
  assign rx_fin   = cpha_q ? {rx_q[W-2:0], miso_i} : rx_q;
  assign rx_o     = lsb_q ? rx_rev : rx_fin;
  assign busy_o   = busy_q;
  assign sclk_o   = sclk_q;
  assign mosi_o   = tx_q[W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      cpha_q <= 1'b0;
      lsb_q  <= 1'b0;
      idle_q <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
      ecnt_q <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
      sclk_q <= idle_i;
    end else if (start_i) begin
      busy_q <= 1'b1;
      sclk_q <= idle_i;
      idle_q <= idle_i;
      cpha_q <= cpha_i;
      lsb_q  <= lsb_i;
      tx_q   <= data_ord;
      ecnt_q <= '0;
    end else if (busy_q && tick_i) begin
      sclk_q <= ~sclk_q;
      ecnt_q <= ecnt_q + EW'(1);
      if (leading) begin
        if (!cpha_q)            rx_q <= {rx_q[W-2:0], miso_i};
        else if (ecnt_q != '0)  tx_q <= {tx_q[W-2:0], 1'b0};
      end else begin
        if (!cpha_q)            tx_q <= {tx_q[W-2:0], 1'b0};
        else                    rx_q <= {rx_q[W-2:0], miso_i};
      end
      if (last_o) busy_q <= 1'b0;
    end else if (!busy_q) begin
      sclk_q <= idle_i;
    end
  end

  // R4: clock only moves on a divider tick inside a transfer
  a_r4_sclk_holds_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !tick_i && !abort_i) |=> $stable(sclk_q));
  // R4: after the last toggle the pin is back at the level it started from
  a_r4_ends_at_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> (!busy_q && sclk_q == idle_q));
  // R6: with phase 0, MOSI never moves on a leading toggle
  a_r6_mosi_still_on_leading: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && tick_i && leading && !cpha_q && !abort_i) |=> $stable(mosi_o));
endmodule

// File: rtl/spi_status.sv
module spi_status #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         last_i,
  input  logic [W-1:0] rx_i,
  input  logic         coll_i,
  input  logic         clr_done_i,
  input  logic         clr_wcol_i,
  output logic         done_o,
  output logic         wcol_o,
  output logic [W-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o  <= 1'b0;
      wcol_o  <= 1'b0;
      rdata_o <= '0;
    end else begin
      if (last_i) begin
        done_o  <= 1'b1;
        rdata_o <= rx_i;
      end else if (clr_done_i) begin
        done_o  <= 1'b0;
      end
      if (coll_i)          wcol_o <= 1'b1;
      else if (clr_wcol_i) wcol_o <= 1'b0;
    end
  end

  a_r8_done_on_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_i |=> done_o);
  a_r8_clear_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_done_i && !last_i) |=> !done_o);
  a_r9_collision_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coll_i |=> wcol_o);
endmodule

// File: rtl/uart_spi_master.sv
module uart_spi_master #(
  parameter int W        = 8,
  parameter int FAST_DIV = 4,
  parameter int SLOW_DIV = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [2:0]   mode_i,
  input  logic         fast_i,
  input  logic         lsb_first_i,
  input  logic         cpha_i,
  input  logic         idle_lvl_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         clr_done_i,
  input  logic         clr_wcol_i,
  input  logic         miso_i,
  output logic         txd_o,
  output logic         rxd_o,
  output logic         busy_o,
  output logic         done_o,
  output logic         wcol_o,
  output logic [W-1:0] rdata_o
);
  import spi_port_pkg::*;

  logic spi_sel, start, abort, coll, tick, last, sclk, mosi, busy;
  logic [W-1:0] rx_word;

  assign spi_sel = mode_is_spi(mode_i);
  assign start   = spi_sel && wr_i && !busy;
  assign coll    = spi_sel && wr_i && busy;
  assign abort   = busy && !spi_sel;

  spi_bit_timer #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .run_i   (busy),
    .fast_i  (fast_i),
    .tick_o  (tick)
  );

  spi_shift_core #(.W(W)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .abort_i (abort),
    .tick_i  (tick),
    .data_i  (wdata_i),
    .lsb_i   (lsb_first_i),
    .cpha_i  (cpha_i),
    .idle_i  (idle_lvl_i),
    .miso_i  (miso_i),
    .busy_o  (busy),
    .sclk_o  (sclk),
    .mosi_o  (mosi),
    .last_o  (last),
    .rx_o    (rx_word)
  );

  spi_status #(.W(W)) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .last_i     (last),
    .rx_i       (rx_word),
    .coll_i     (coll),
    .clr_done_i (clr_done_i),
    .clr_wcol_i (clr_wcol_i),
    .done_o     (done_o),
    .wcol_o     (wcol_o),
    .rdata_o    (rdata_o)
  );

  // UART functions own the pins in other modes; here they rest high
  assign txd_o  = spi_sel ? sclk : 1'b1;
  assign rxd_o  = spi_sel ? mosi : 1'b1;
  assign busy_o = busy;

  a_r2_idle_outside_spi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !spi_sel |=> !busy);
  a_r2_pins_high_outside_spi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !spi_sel |-> (txd_o && rxd_o));
  a_r9_write_while_busy_keeps_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coll && !last) |=> busy);
endmodule

// File: tb/uart_spi_master_tb.sv
module uart_spi_master_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode = 3'd4;
  logic       fast = 1'b1, lsb = 1'b0, cpha = 1'b0, idle = 1'b0;
  logic       wr = 1'b0, clr_done = 1'b0, clr_wcol = 1'b0, miso = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       txd, rxd, busy, done, wcol;
  logic [7:0] rdata;

  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  uart_spi_master u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .fast_i(fast),
    .lsb_first_i(lsb), .cpha_i(cpha), .idle_lvl_i(idle), .wr_i(wr),
    .wdata_i(wdata), .clr_done_i(clr_done), .clr_wcol_i(clr_wcol),
    .miso_i(miso), .txd_o(txd), .rxd_o(rxd), .busy_o(busy),
    .done_o(done), .wcol_o(wcol), .rdata_o(rdata)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] d);
    for (int i = 0; i < 8; i++) rev8[i] = d[7-i];
  endfunction

  typedef struct packed { logic [7:0] mosi_exp; logic [7:0] rx_exp; } item_t;
  item_t sb_q[$];

  // slave model / monitor state
  logic [7:0] s_seq;
  logic       prev_sclk = 1'b0, prev_busy = 1'b0, in_x = 1'b0;
  int         edge_idx = 0, gap = 0;
  logic [7:0] cap;

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && !prev_busy) begin
        in_x = 1'b1; gap = 0; edge_idx = 0; cap = 8'h00;
      end else if (in_x) begin
        gap++;
      end
      if (in_x && txd != prev_sclk) begin
        edge_idx++;
        chk(gap == (fast ? 2 : 6), "R3 half-period", gap, fast ? 2 : 6);
        gap = 0;
        if (edge_idx % 2 == 1) begin
          if (!cpha) cap = {cap[6:0], rxd};                  // R6 sample on leading
          else if (edge_idx < 16) miso = s_seq[7-(edge_idx-1)/2]; // R7 launch
        end else begin
          if (cpha) cap = {cap[6:0], rxd};                   // R7 sample on trailing
          else if (edge_idx < 16) miso = s_seq[7-edge_idx/2];
        end
        if (edge_idx == 16) begin
          item_t it;
          in_x = 1'b0;
          chk(txd == idle, "R4 back to idle", txd, idle);
          chk(done == 1'b1, "R8 done at last toggle", done, 1);
          if (sb_q.size() == 0) begin
            chk(1'b0, "R8 unexpected completion", 0, 1);
          end else begin
            it = sb_q.pop_front();
            chk(cap == it.mosi_exp, cpha ? "R7 mosi stream" : "R6 mosi stream", cap, it.mosi_exp);
            chk(rdata == it.rx_exp, "R5 received byte", rdata, it.rx_exp);
          end
        end
      end
      if (in_x && !busy) in_x = 1'b0;  // aborted
      prev_busy = busy;
      prev_sclk = txd;
    end
  end

  task automatic pulse_wr(input logic [7:0] d);
    @(posedge clk); #1 wdata = d; wr = 1'b1;
    @(posedge clk); #1 wr = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic xfer(input logic i_idle, input logic i_cpha, input logic i_lsb,
                      input logic i_fast, input logic [7:0] tx, input logic [7:0] sl);
    item_t it;
    @(posedge clk); #1;
    idle = i_idle; cpha = i_cpha; lsb = i_lsb; fast = i_fast;
    s_seq = i_lsb ? rev8(sl) : sl;
    miso = s_seq[7];
    it.mosi_exp = i_lsb ? rev8(tx) : tx;
    it.rx_exp = sl;
    sb_q.push_back(it);
    repeat (2) @(posedge clk);
    #1 chk(txd == i_idle, "R4 idle level before start", txd, i_idle);
    pulse_wr(tx);
    wait_idle();
    @(posedge clk); #1 clr_done = 1'b1;
    @(posedge clk); #1 clr_done = 1'b0;
    @(negedge clk) chk(done == 1'b0, "R8 clear done", done, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && wcol == 0, "R1 flags in reset", {busy, done, wcol}, 0);
    chk(rdata == 8'h00, "R1 rdata in reset", rdata, 0);
    chk(txd == 0 && rxd == 0, "R1 pins in reset", {txd, rxd}, 0);
    @(posedge clk); #1 rst_n = 1'b1;

    // four polarity/phase combinations, both orders and speeds
    xfer(0, 0, 0, 1, 8'hA5, 8'h3C);
    xfer(1, 0, 1, 0, 8'h81, 8'h7E);
    xfer(0, 1, 0, 0, 8'h5A, 8'hC3);
    xfer(1, 1, 1, 1, 8'h01, 8'h80);
    xfer(0, 1, 1, 1, 8'h00, 8'hFF);
    xfer(1, 0, 0, 1, 8'hFF, 8'h00);
    xfer(1, 1, 0, 0, 8'h80, 8'h01);
    xfer(0, 0, 1, 0, 8'h36, 8'hE4);

    // R9: write during a transfer is ignored and flagged
    begin
      item_t it;
      @(posedge clk); #1;
      idle = 0; cpha = 0; lsb = 0; fast = 0;
      s_seq = 8'h69; miso = s_seq[7];
      it.mosi_exp = 8'h96; it.rx_exp = 8'h69;
      sb_q.push_back(it);
      pulse_wr(8'h96);
      repeat (10) @(posedge clk);
      pulse_wr(8'h11);
      @(negedge clk) chk(wcol == 1'b1, "R9 collision flag", wcol, 1);
      chk(busy == 1'b1, "R9 transfer continues", busy, 1);
      wait_idle();
      @(posedge clk); #1 clr_wcol = 1'b1; clr_done = 1'b1;
      @(posedge clk); #1 clr_wcol = 1'b0; clr_done = 1'b0;
      @(negedge clk) chk(wcol == 1'b0, "R9 clear collision", wcol, 0);
    end

    // R2: non-SPI modes ignore writes and rest the pins high
    for (int m = 0; m < 8; m++) begin
      if (m != 4) begin
        @(posedge clk); #1 mode = 3'(m);
        pulse_wr(8'hC5);
        repeat (20) @(negedge clk);
        chk(busy == 0 && done == 0 && wcol == 0, "R2 ignored in non-SPI mode", {busy, done, wcol}, 0);
        chk(txd == 1 && rxd == 1, "R2 pins high in non-SPI mode", {txd, rxd}, 3);
      end
    end
    @(posedge clk); #1 mode = 3'd4;

    // R2: leaving SPI mode mid-transfer aborts without completion
    @(posedge clk); #1 idle = 0; fast = 0; s_seq = 8'h00; miso = 1'b0;
    pulse_wr(8'hF0);
    repeat (8) @(posedge clk);
    #1 mode = 3'd2;
    repeat (20) @(negedge clk);
    chk(busy == 0 && done == 0, "R2 abort on mode change", {busy, done}, 0);
    @(posedge clk); #1 mode = 3'd4;
    repeat (3) @(negedge clk);
    chk(txd == idle, "R4 idle after abort", txd, idle);
    chk(sb_q.size() == 0, "R8 all transfers completed", sb_q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule